// File: doc/BRIEF.md
# Asynchronous Microprocessor Write Port with Ready Handshake

This block accepts write cycles from an asynchronous microprocessor bus. The bus has an active-low chip select, an active-low write strobe, an address-space select line, a 15-bit word address and a 16-bit data word. The block turns each cycle into a single-clock write into an internal register bank, which runs on the device's master clock (nominally 60 MHz). The host holds its strobes until the block's ready line returns high. The block pulls ready low shortly after it detects the write, so the host waits out a bounded internal latency.

Both strobes pass through two-flop synchronizers. A controller with five named states runs every cycle:

- ST_IDLE: ready is high. The controller leaves on `start` when the synchronized chip select and write strobe are both low.
- ST_CAPTURE: one clock, ready low. Address, space and data go into holding registers. Transition `cap_done` leads to ST_WAIT.
- ST_WAIT: ready stays low. The write pulse is issued in the last cycle, then transition `lat_done` leads to ST_ACK.
- ST_ACK: ready is high. The controller leaves on `release` when either synchronized strobe goes high.
- ST_GAP: a fixed run of idle clocks during which the strobes are ignored. Transition `gap_done` returns to ST_IDLE.

Top module: `async_cpu_wrport`

## Requirements
- R1: A write starts only when chip select and write strobe are both low (0 = asserted). With only one of them low, ready stays high, no write pulse occurs and the holding registers keep their previous values.
- R2: Ready falls at the third rising clock edge after both strobes go low at the pins: two synchronizer stages plus one state register.
- R3: Ready stays low for exactly L clocks. L is 8 when `lat_cfg` is 0. Otherwise L is `lat_cfg` clamped to the range 7 to 59.
- R4: Each write cycle produces exactly one `reg_we` pulse, one clock wide, in the last clock that ready is low.
- R5: During the pulse, `reg_addr`, `reg_space` and `reg_data` equal the bus values present when the write was detected.
- R6: After the write is acknowledged, ready stays high and no further pulse occurs while both strobes remain low.
- R7: If the strobes go high before the acknowledge, the write still completes. It uses the captured values, not later bus contents, and keeps the same latency.
- R8: After the strobes are released, four idle clocks follow. Strobe activity that ends within them starts no cycle.
- R9: During reset, ready is high, `reg_we` is low and the holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel_n | input | 1 | Chip select, active low, asynchronous |
| cpu_wr_n | input | 1 | Write strobe, active low, asynchronous |
| cpu_space | input | 1 | Address-space select, captured with the address |
| cpu_addr | input | 15 | Word address |
| cpu_data | input | 16 | Write data |
| lat_cfg | input | 6 | Write latency setting; 0 selects the default |
| cpu_rdy | output | 1 | Ready; low inserts wait states |
| reg_we | output | 1 | One-clock write enable to the register bank |
| reg_space | output | 1 | Captured address-space select |
| reg_addr | output | 15 | Captured word address |
| reg_data | output | 16 | Captured write data |

## Verification
The assertions check, on every clock, the following properties:
- a detected start pulls ready low in the next clock;
- the write pulse is never wider than one clock and only occurs while ready is low;
- the idle state holds without a start;
- the acknowledge state holds ready high while both strobes stay low;
- the gap state can only lead to itself or to idle.

Only the bench scenarios can show the rest:
- the exact three-edge delay from the pins;
- the clamped latency length for each setting;
- that the pulse carries the captured bus values even when the bus changes early;
- that a strobe glitch inside the gap is ignored at the ports.

// File: rtl/wrport_pkg.sv
package wrport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_WAIT,
        ST_ACK,
        ST_GAP
    } wr_state_e;
endpackage

// File: rtl/wrport_sync.sv
module wrport_sync #(
    parameter int          W        = 2,
    parameter logic        RST_VAL  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= async_in[b];
                stab_q <= meta_q;
            end
        end
        assign sync_out[b] = stab_q;
    end
endmodule

// File: rtl/wrport_hold.sv
module wrport_hold #(
    parameter int AW = 15,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          in_space,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_space,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_space <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (load) begin
            out_space <= in_space;
            out_addr  <= in_addr;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/wrport_fsm.sv
module wrport_fsm
    import wrport_pkg::*;
#(
    parameter int LCW         = 6,
    parameter int LAT_DEFAULT = 8,
    parameter int LAT_MIN     = 7,
    parameter int LAT_MAX     = 59,
    parameter int GAP_CLKS    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_s_n,
    input  logic           wr_s_n,
    input  logic [LCW-1:0] lat_cfg,
    output logic           rdy,
    output logic           we,
    output logic           cap_load
);
    localparam int CW = $clog2(LAT_MAX + 1);
    localparam int GW = $clog2(GAP_CLKS + 1);

    wr_state_e      state, nxt;
    logic [CW-1:0]  lat_cnt;
    logic [CW-1:0]  lat_q;
    logic [CW-1:0]  lat_eff;
    logic [GW-1:0]  gap_cnt;
    logic           both_s;
    logic           lat_hit;
    logic           gap_hit;

    assign both_s  = !sel_s_n && !wr_s_n;
    assign lat_hit = (lat_cnt == lat_q - 1'b1);
    assign gap_hit = (gap_cnt == GW'(GAP_CLKS - 1));

    always_comb begin
        if (lat_cfg == '0)
            lat_eff = CW'(LAT_DEFAULT);
        else if (int'(lat_cfg) < LAT_MIN)
            lat_eff = CW'(LAT_MIN);
        else if (int'(lat_cfg) > LAT_MAX)
            lat_eff = CW'(LAT_MAX);
        else
            lat_eff = CW'(lat_cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            gap_cnt <= '0;
            lat_q   <= CW'(LAT_DEFAULT);
        end else begin
            lat_cnt <= (state == ST_CAPTURE || state == ST_WAIT) ? lat_cnt + 1'b1 : '0;
            gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
            if (state == ST_IDLE && both_s) lat_q <= lat_eff;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (both_s)  nxt = ST_CAPTURE;
            ST_CAPTURE:              nxt = ST_WAIT;
            ST_WAIT:    if (lat_hit) nxt = ST_ACK;
            ST_ACK:     if (!both_s) nxt = ST_GAP;
            ST_GAP:     if (gap_hit) nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rdy      = 1'b1;
        we       = 1'b0;
        cap_load = 1'b0;
        unique case (state)
            ST_CAPTURE: begin rdy = 1'b0; cap_load = 1'b1; end
            ST_WAIT:    begin rdy = 1'b0; we = lat_hit; end
            default:    ;
        endcase
    end

    // R2
    start_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && both_s) |=> !rdy);
    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);
    // R4
    we_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !rdy);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !both_s) |=> (state == ST_IDLE && rdy));
    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && both_s) |=> (state == ST_ACK && rdy && !we));
    // R8
    gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (state == ST_GAP || state == ST_IDLE));
endmodule

// File: rtl/async_cpu_wrport.sv
module async_cpu_wrport #(
    parameter int AW          = 15,
    parameter int DW          = 16,
    parameter int LCW         = 6,
    parameter int LAT_DEFAULT = 8,
    parameter int LAT_MIN     = 7,
    parameter int LAT_MAX     = 59,
    parameter int GAP_CLKS    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_sel_n,
    input  logic           cpu_wr_n,
    input  logic           cpu_space,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_data,
    input  logic [LCW-1:0] lat_cfg,
    output logic           cpu_rdy,
    output logic           reg_we,
    output logic           reg_space,
    output logic [AW-1:0]  reg_addr,
    output logic [DW-1:0]  reg_data
);
    logic [1:0] strobe_s;
    logic       cap_load;

    wrport_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cpu_wr_n, cpu_sel_n}),
        .sync_out (strobe_s)
    );

    wrport_fsm #(
        .LCW         (LCW),
        .LAT_DEFAULT (LAT_DEFAULT),
        .LAT_MIN     (LAT_MIN),
        .LAT_MAX     (LAT_MAX),
        .GAP_CLKS    (GAP_CLKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s_n  (strobe_s[0]),
        .wr_s_n   (strobe_s[1]),
        .lat_cfg  (lat_cfg),
        .rdy      (cpu_rdy),
        .we       (reg_we),
        .cap_load (cap_load)
    );

    wrport_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_load),
        .in_space  (cpu_space),
        .in_addr   (cpu_addr),
        .in_data   (cpu_data),
        .out_space (reg_space),
        .out_addr  (reg_addr),
        .out_data  (reg_data)
    );
endmodule

// File: tb/test_async_cpu_wrport.sv
module test_async_cpu_wrport;
    typedef struct packed {
        logic [14:0] a;
        logic        s;
        logic [15:0] d;
        logic [5:0]  cfg;
        logic [6:0]  exp_l;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{15'h0001, 1'b0, 16'hA5A5, 6'd0,  7'd8},
        '{15'h7FFF, 1'b1, 16'h1234, 6'd7,  7'd7},
        '{15'h2AAA, 1'b0, 16'hFFFF, 6'd3,  7'd7},
        '{15'h5555, 1'b1, 16'h0000, 6'd59, 7'd59},
        '{15'h0100, 1'b0, 16'h8001, 6'd63, 7'd59},
        '{15'h1357, 1'b1, 16'h2468, 6'd20, 7'd20},
        '{15'h0F0F, 1'b0, 16'hC3C3, 6'd1,  7'd7},
        '{15'h3C3C, 1'b1, 16'h5A5A, 6'd60, 7'd59}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel_n = 1'b1;
    logic        cpu_wr_n = 1'b1;
    logic        cpu_space = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [15:0] cpu_data = '0;
    logic [5:0]  lat_cfg = '0;
    logic        cpu_rdy, reg_we, reg_space;
    logic [14:0] reg_addr;
    logic [15:0] reg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    async_cpu_wrport i_async_cpu_wrport (
        .clk(clk), .rst_n(rst_n), .cpu_sel_n(cpu_sel_n), .cpu_wr_n(cpu_wr_n),
        .cpu_space(cpu_space), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .lat_cfg(lat_cfg), .cpu_rdy(cpu_rdy), .reg_we(reg_we),
        .reg_space(reg_space), .reg_addr(reg_addr), .reg_data(reg_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_write(input vec_t v, input bit early);
        int  c = 0, first = 0, lows = 0, wes = 0, weat = 0;
        bit  dok = 1'b1, done = 1'b0, extra = 1'b0;
        @(negedge clk);
        cpu_addr = v.a; cpu_space = v.s; cpu_data = v.d; lat_cfg = v.cfg;
        cpu_sel_n = 1'b0; cpu_wr_n = 1'b0;
        while (!done && c < 200) begin
            @(negedge clk);
            c++;
            if (early && c == 4) begin
                cpu_sel_n = 1'b1; cpu_wr_n = 1'b1;
                cpu_addr = ~v.a; cpu_space = ~v.s; cpu_data = ~v.d;
            end
            if (!cpu_rdy) begin
                if (first == 0) first = c;
                lows++;
            end else if (first != 0) done = 1'b1;
            if (reg_we) begin
                wes++; weat = c;
                if (reg_addr != v.a || reg_space != v.s || reg_data != v.d) dok = 1'b0;
            end
        end
        chk(first == 3, "R2", "ready fall edge", first, 3);
        chk(lows == int'(v.exp_l), "R3", "ready low clocks", lows, v.exp_l);
        chk(wes == 1, "R4", "write pulses", wes, 1);
        chk(weat == first + lows - 1, "R4", "pulse position", weat, first + lows - 1);
        chk(dok, early ? "R7" : "R5", "captured values at pulse", dok, 1);
        if (!early) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (!cpu_rdy || reg_we) extra = 1'b1;
            end
            chk(!extra, "R6", "ready held high after ack", extra, 0);
            cpu_sel_n = 1'b1; cpu_wr_n = 1'b1;
            cpu_addr = ~v.a; cpu_data = ~v.d;
        end
        extra = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (reg_we || !cpu_rdy) extra = 1'b1;
        end
        chk(!extra, "R8", "quiet after release", extra, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(cpu_rdy && !reg_we, "R9", "rdy/we in reset", {cpu_rdy, reg_we}, 2'b10);
        chk(reg_addr == 0 && reg_data == 0 && !reg_space, "R9", "holding regs in reset",
            reg_data, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        foreach (VECS[k]) run_write(VECS[k], 1'b0);

        // R1: chip select alone, then write strobe alone
        cpu_addr = 15'h1111; cpu_data = 16'hBEEF; cpu_space = 1'b0;
        seen = 1'b0;
        cpu_sel_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cpu_rdy || reg_we) seen = 1'b1;
        end
        cpu_sel_n = 1'b1; cpu_wr_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cpu_rdy || reg_we) seen = 1'b1;
        end
        cpu_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!seen, "R1", "single strobe activity", seen, 0);
        chk(reg_data == VECS[NV-1].d, "R1", "holding data untouched", reg_data, VECS[NV-1].d);

        // R7: strobes dropped before acknowledge
        run_write('{15'h0ABC, 1'b1, 16'h7E7E, 6'd12, 7'd12}, 1'b1);
        run_write('{15'h0DEF, 1'b0, 16'h0F0F, 6'd0,  7'd8},  1'b1);

        // R8: strobe glitch inside the gap
        @(negedge clk);
        cpu_addr = 15'h0042; cpu_data = 16'h4242; cpu_space = 1'b0; lat_cfg = 6'd7;
        cpu_sel_n = 1'b0; cpu_wr_n = 1'b0;
        while (cpu_rdy) @(negedge clk);
        while (!cpu_rdy) @(negedge clk);
        cpu_sel_n = 1'b1; cpu_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cpu_data = 16'hDEAD; cpu_sel_n = 1'b0; cpu_wr_n = 1'b0;
        @(negedge clk);
        cpu_sel_n = 1'b1; cpu_wr_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cpu_rdy || reg_we) seen = 1'b1;
        end
        chk(!seen, "R8", "glitch in gap started a cycle", seen, 0);
        chk(reg_data == 16'h4242, "R8", "holding data after gap glitch", reg_data, 16'h4242);

        // R6/R5: a write after the gap still works
        run_write('{15'h6006, 1'b1, 16'h9009, 6'd9, 7'd9}, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule